// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output-compare channel of a general-purpose timer. The counter is outside the block. Each cycle the block sees the counter value, the counting direction and a counter-enable tick. From these and a programmable compare value it drives a single active-high reference signal. Polarity inversion, complementary outputs and input capture belong to other blocks.

A 4-bit mode code selects the behaviour. Its most significant bit arrives on its own pin, apart from the three low bits. The code selects one of these behaviours:
- level changes on a compare match (set, clear, toggle),
- a forced level,
- one of two direction-aware PWM shapes,
- a frozen state that holds the current level.

The compare value can be double-buffered behind a shadow register that is loaded into the active copy on an update-event pulse. A fast path lets a trigger edge stand in for a match. An external clear input, when enabled, pulls the reference low.

Top module: `oc_channel`

## Requirements
- R1: After reset the reference output is low and both the shadow and the active compare value are zero.
- R2: With preload disabled, a compare write appears on the active compare value one clock after the write strobe.
- R3: With preload enabled, a compare write changes only the shadow value. The active value stays unchanged until an update pulse, and one clock after that pulse it equals the shadow value.
- R4: The mode code is {mode_hi_i, mode_lo_i}. Code 0 and every code from 8 to 15 are frozen, and in those codes the reference keeps its level whatever the counter, ticks or compare value do.
- R5: Code 1 drives the reference high and code 2 drives it low, one clock after a tick on which counter equals compare. Without a tick, or without equality, there is no change.
- R6: Code 3 inverts the reference one clock after each tick on which counter equals compare, and leaves it alone on other ticks.
- R7: Code 4 forces the reference low and code 5 forces it high, one clock after the code is applied, with no tick needed.
- R8: Code 6 (PWM 1) evaluates on each tick. Counting up, the level is high when counter < compare and low otherwise. Counting down, the level is low when counter > compare and high otherwise.
- R9: Code 7 (PWM 2) gives the inverse of code 6 in both directions.
- R10: In codes 6 and 7 the reference is reloaded on a tick only in these cases: the raw comparison result differs from the one at the previous tick, the previous tick saw a frozen code, or an external clear happened since the last tick. Otherwise the reference keeps its level.
- R11: With fast enable set and code 1, 2 or 3, a rising edge on the trigger input acts as a match one clock later, with no tick needed. A held-high trigger gives no further match. With fast enable clear, trigger edges have no effect.
- R12: While clear enable and the external clear input are both high, the reference is low from the next clock on. With clear enable low the clear input has no effect. After the clear input drops, forced codes resume on the next clock and PWM codes reload their level on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter-enable tick; compare evaluation strobe |
| cnt_i | input | CNT_W | Current counter value |
| dir_down_i | input | 1 | 1 = counter is counting down |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value to write |
| preload_en_i | input | 1 | 1 = writes go to the shadow register |
| update_i | input | 1 | Update-event pulse: shadow copied to active |
| mode_lo_i | input | 3 | Mode code bits 2..0 |
| mode_hi_i | input | 1 | Mode code bit 3 |
| fast_en_i | input | 1 | Trigger edge counts as a match |
| trig_i | input | 1 | Trigger input |
| clr_en_i | input | 1 | Enables the external clear |
| ext_clr_i | input | 1 | External clear level |
| ref_o | output | 1 | Active-high reference output |
| cmp_active_o | output | CNT_W | Active compare value |

## Verification
The bench builds the block with CNT_W = 8. At that width the all-ones counter value 255 and a matching compare value of 255 can be reached in a few writes, so the equality boundary at full scale is exercised directly. The small width also keeps both PWM directions around a compare value of 10 within a handful of ticks. That makes it cheap to walk through the comparison-change rule of R10, including a switch between the two PWM codes with the comparison unchanged.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
  typedef enum logic [2:0] {
    OC_FROZEN = 3'd0,
    OC_SET    = 3'd1,
    OC_CLR    = 3'd2,
    OC_TGL    = 3'd3,
    OC_LOW    = 3'd4,
    OC_HIGH   = 3'd5,
    OC_PWM1   = 3'd6,
    OC_PWM2   = 3'd7
  } oc_mode_e;

  // codes 8..15 collapse to frozen
  function automatic oc_mode_e oc_decode(input logic hi, input logic [2:0] lo);
    return hi ? OC_FROZEN : oc_mode_e'(lo);
  endfunction
endpackage

// File: rtl/oc_cmp_reg.sv
`timescale 1ns/1ps
module oc_cmp_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         preload_en_i,
  input  logic         update_i,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_i) shadow_q <= wdata_i;
      if (wr_i && !preload_en_i) active_q <= wdata_i;
      else if (update_i)         active_q <= shadow_q;
    end
  end

  assign active_o = active_q;

  a_r2_direct_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !preload_en_i) |=> active_o == $past(wdata_i));
  a_r3_preload_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload_en_i && !update_i) |=> $stable(active_o));
  a_r3_update_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !(wr_i && !preload_en_i)) |=> active_o == $past(shadow_q));
endmodule

// File: rtl/oc_trig_edge.sv
`timescale 1ns/1ps
module oc_trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/oc_ref_gen.sv
`timescale 1ns/1ps
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  oc_mode_e     mode_i,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         dir_down_i,
  input  logic         fast_i,
  input  logic         clr_i,
  output logic         ref_o
);
  logic ref_q, ref_d;
  logic raw_q, frz_q, resync_q;
  logic eq, raw, hit, is_pwm, pwm_lvl, pwm_load;

  always_comb begin
    eq       = (cnt_i == cmp_i);
    // PWM1 level: up -> cnt<cmp, down -> cnt<=cmp
    raw      = dir_down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);
    pwm_lvl  = (mode_i == OC_PWM2) ? ~raw : raw;
    is_pwm   = (mode_i == OC_PWM1) || (mode_i == OC_PWM2);
    hit      = (tick_i && eq) || fast_i;
    pwm_load = tick_i && ((raw != raw_q) || frz_q || resync_q);
    ref_d    = ref_q;
    if (clr_i) begin
      ref_d = 1'b0;
    end else begin
      unique case (mode_i)
        OC_LOW:  ref_d = 1'b0;
        OC_HIGH: ref_d = 1'b1;
        OC_SET:  if (hit) ref_d = 1'b1;
        OC_CLR:  if (hit) ref_d = 1'b0;
        OC_TGL:  if (hit) ref_d = ~ref_q;
        OC_PWM1, OC_PWM2: if (pwm_load) ref_d = pwm_lvl;
        default: ref_d = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q    <= 1'b0;
      raw_q    <= 1'b0;
      frz_q    <= 1'b1;
      resync_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      if (tick_i) begin
        raw_q <= raw;
        frz_q <= (mode_i == OC_FROZEN);
      end
      if (clr_i)       resync_q <= 1'b1;
      else if (tick_i) resync_q <= 1'b0;
    end
  end

  assign ref_o = ref_q;

  a_r12_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ref_o);
  a_r7_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && mode_i == OC_HIGH) |=> ref_o);
  a_r7_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_LOW) |=> !ref_o);
  a_r4_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && mode_i == OC_FROZEN) |=> $stable(ref_o));
  a_r5_set_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && mode_i == OC_SET && tick_i && eq) |=> ref_o);
  a_r10_pwm_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && is_pwm && !tick_i) |=> $stable(ref_o));
endmodule

// File: rtl/oc_channel.sv
`timescale 1ns/1ps
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_down_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             preload_en_i,
  input  logic             update_i,
  input  logic [2:0]       mode_lo_i,
  input  logic             mode_hi_i,
  input  logic             fast_en_i,
  input  logic             trig_i,
  input  logic             clr_en_i,
  input  logic             ext_clr_i,
  output logic             ref_o,
  output logic [CNT_W-1:0] cmp_active_o
);
  oc_mode_e         mode;
  logic             trig_rise, fast_hit, clr_act;
  logic [CNT_W-1:0] cmp_act;

  assign mode     = oc_decode(mode_hi_i, mode_lo_i);
  assign fast_hit = fast_en_i & trig_rise;
  assign clr_act  = clr_en_i & ext_clr_i;

  oc_cmp_reg #(.W(CNT_W)) u_cmp (
    .clk_i, .rst_ni,
    .wr_i         (cmp_wr_i),
    .wdata_i      (cmp_wdata_i),
    .preload_en_i (preload_en_i),
    .update_i     (update_i),
    .active_o     (cmp_act)
  );

  oc_trig_edge u_trig (
    .clk_i, .rst_ni,
    .trig_i (trig_i),
    .rise_o (trig_rise)
  );

  oc_ref_gen #(.W(CNT_W)) u_ref (
    .clk_i, .rst_ni,
    .mode_i     (mode),
    .tick_i     (tick_i),
    .cnt_i      (cnt_i),
    .cmp_i      (cmp_act),
    .dir_down_i (dir_down_i),
    .fast_i     (fast_hit),
    .clr_i      (clr_act),
    .ref_o      (ref_o)
  );

  assign cmp_active_o = cmp_act;

  a_r11_fast_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_en_i && !tick_i && !clr_act && mode inside {OC_SET, OC_CLR, OC_TGL})
      |=> $stable(ref_o));
endmodule

// File: tb/tb_oc_channel.sv
`timescale 1ns/1ps
module tb_oc_channel;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic [W-1:0] cnt_i = '0;
  logic         dir_down_i = 1'b0;
  logic         cmp_wr_i = 1'b0;
  logic [W-1:0] cmp_wdata_i = '0;
  logic         preload_en_i = 1'b0;
  logic         update_i = 1'b0;
  logic [2:0]   mode_lo_i = '0;
  logic         mode_hi_i = 1'b0;
  logic         fast_en_i = 1'b0;
  logic         trig_i = 1'b0;
  logic         clr_en_i = 1'b0;
  logic         ext_clr_i = 1'b0;
  logic         ref_o;
  logic [W-1:0] cmp_active_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  oc_channel #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_ni, .tick_i, .cnt_i, .dir_down_i, .cmp_wr_i, .cmp_wdata_i,
    .preload_en_i, .update_i, .mode_lo_i, .mode_hi_i, .fast_en_i, .trig_i,
    .clr_en_i, .ext_clr_i, .ref_o, .cmp_active_o
  );

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_mode(int m);
    mode_hi_i = m[3];
    mode_lo_i = m[2:0];
  endtask

  task automatic do_tick(int c, bit down);
    cnt_i = W'(c); dir_down_i = down; tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  task automatic wr_cmp(int v);
    cmp_wr_i = 1'b1; cmp_wdata_i = W'(v);
    step();
    cmp_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ref", int'(ref_o), 0);
    chk("R1 active", int'(cmp_active_o), 0);
  endtask

  task automatic t_preload_off();
    preload_en_i = 1'b0;
    wr_cmp(5);
    chk("R2 direct", int'(cmp_active_o), 5);
  endtask

  task automatic t_preload_on();
    preload_en_i = 1'b1;
    wr_cmp(9);
    chk("R3 held", int'(cmp_active_o), 5);
    step();
    chk("R3 held2", int'(cmp_active_o), 5);
    update_i = 1'b1; step(); update_i = 1'b0;
    chk("R3 update", int'(cmp_active_o), 9);
    preload_en_i = 1'b0;
  endtask

  task automatic t_set_clr();
    wr_cmp(255);
    set_mode(1);
    do_tick(254, 0);
    chk("R5 no eq", int'(ref_o), 0);
    cnt_i = 8'hFF; step();
    chk("R5 no tick", int'(ref_o), 0);
    do_tick(255, 0);
    chk("R5 set", int'(ref_o), 1);
    set_mode(2);
    do_tick(254, 0);
    chk("R5 clr no eq", int'(ref_o), 1);
    do_tick(255, 0);
    chk("R5 clr", int'(ref_o), 0);
  endtask

  task automatic t_toggle();
    set_mode(3);
    do_tick(255, 0);
    chk("R6 tgl1", int'(ref_o), 1);
    do_tick(16, 0);
    chk("R6 no eq", int'(ref_o), 1);
    do_tick(255, 1);
    chk("R6 tgl2", int'(ref_o), 0);
  endtask

  task automatic t_force();
    set_mode(5); step();
    chk("R7 high", int'(ref_o), 1);
    set_mode(4); step();
    chk("R7 low", int'(ref_o), 0);
  endtask

  task automatic t_frozen();
    set_mode(5); step();
    set_mode(0);
    do_tick(255, 0);
    chk("R4 frozen hi", int'(ref_o), 1);
    set_mode(4); step();
    set_mode(9);
    do_tick(255, 0);
    chk("R4 code9", int'(ref_o), 0);
    set_mode(13); step();
    chk("R4 code13", int'(ref_o), 0);
  endtask

  task automatic t_pwm1();
    wr_cmp(10);
    set_mode(0); do_tick(0, 0);
    set_mode(6);
    do_tick(3, 0);   chk("R8 up lt", int'(ref_o), 1);
    do_tick(10, 0);  chk("R8 up eq", int'(ref_o), 0);
    do_tick(12, 0);  chk("R8 up gt", int'(ref_o), 0);
    do_tick(12, 1);  chk("R8 dn gt", int'(ref_o), 0);
    do_tick(10, 1);  chk("R8 dn eq", int'(ref_o), 1);
    do_tick(11, 1);  chk("R8 dn gt2", int'(ref_o), 0);
  endtask

  task automatic t_pwm2();
    set_mode(0); do_tick(0, 0);
    set_mode(7);
    do_tick(3, 0);   chk("R9 up lt", int'(ref_o), 0);
    do_tick(11, 0);  chk("R9 up gt", int'(ref_o), 1);
    do_tick(11, 1);  chk("R9 dn gt", int'(ref_o), 1);
    do_tick(9, 1);   chk("R9 dn lt", int'(ref_o), 0);
  endtask

  task automatic t_pwm_hold();
    set_mode(6);
    do_tick(3, 0);   chk("R10 switch same cmp", int'(ref_o), 0);
    do_tick(12, 0);  chk("R10 change", int'(ref_o), 0);
    do_tick(3, 0);   chk("R10 change2", int'(ref_o), 1);
    set_mode(4); step();
    set_mode(6);
    do_tick(4, 0);   chk("R10 no reload", int'(ref_o), 0);
    do_tick(12, 0);  chk("R10 lvl low", int'(ref_o), 0);
    do_tick(3, 0);   chk("R10 lvl high", int'(ref_o), 1);
  endtask

  task automatic t_fast();
    set_mode(4); step();
    set_mode(1);
    fast_en_i = 1'b0; trig_i = 1'b1; step();
    chk("R11 disabled", int'(ref_o), 0);
    trig_i = 1'b0; step();
    fast_en_i = 1'b1; trig_i = 1'b1; step();
    chk("R11 edge set", int'(ref_o), 1);
    set_mode(2); step();
    chk("R11 held trig", int'(ref_o), 1);
    trig_i = 1'b0; step();
    trig_i = 1'b1; step();
    chk("R11 edge clr", int'(ref_o), 0);
    trig_i = 1'b0; fast_en_i = 1'b0; step();
  endtask

  task automatic t_clear();
    set_mode(5); step();
    clr_en_i = 1'b0; ext_clr_i = 1'b1; step();
    chk("R12 not enabled", int'(ref_o), 1);
    clr_en_i = 1'b1; step();
    chk("R12 cleared", int'(ref_o), 0);
    step();
    chk("R12 held", int'(ref_o), 0);
    ext_clr_i = 1'b0; step();
    chk("R12 force resume", int'(ref_o), 1);
    set_mode(6);
    do_tick(3, 0);
    chk("R12 pwm pre", int'(ref_o), 1);
    ext_clr_i = 1'b1; step();
    chk("R12 pwm clr", int'(ref_o), 0);
    do_tick(4, 0);
    chk("R12 tick in clr", int'(ref_o), 0);
    ext_clr_i = 1'b0; step();
    chk("R12 wait tick", int'(ref_o), 0);
    do_tick(5, 0);
    chk("R12 pwm resync", int'(ref_o), 1);
    clr_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_preload_off();
    t_preload_on();
    t_set_clr();
    t_toggle();
    t_force();
    t_frozen();
    t_pwm1();
    t_pwm2();
    t_pwm_hold();
    t_fast();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule